// File: doc/BRIEF.md
# Parallel-In Serial-Out FIFO Buffer

This block stores 9-bit words written on a parallel port and sends them out one bit per shift-enabled clock on a single serial line. Writes and serial shifts are independent enables on one clock, so both can take effect in the same cycle. The word at the head of the queue drives the serial line directly, so a word written into an empty buffer is on the line one cycle later with no separate read step.

The serial word length is set at run time. A next-read input, sampled together with the shift enable, makes the current bit the last one of the word and moves to the next stored word. Without it the shifter moves to the next word by itself after the ninth bit. Four status outputs report occupancy: full, empty, half-full and one combined near-boundary output that is high when the buffer is within one eighth of its depth of either empty or full. A retransmit input rewinds the read side to the first word written since reset, as long as no more than one full depth of words has been written.

Top module: `piso_fifo`

## Requirements
- R1: While rst_ni is low and after it is released, with no other activity, empty_o and edge_o are 1, full_o and half_o are 0, and ser_o is 0.
- R2: A word written while the buffer is empty drives its bit 0 on ser_o in the cycle after the write edge, and empty_o goes to 0 in that same cycle.
- R3: Each stored word is sent least significant bit first: before the k-th shift of a word (k counted from 0), ser_o equals bit k of that word.
- R4: A shift with next_rd_i high makes the bit on ser_o the last of its word; the next cycle presents bit 0 of the following word, so words of 1 to 9 bits can be sent.
- R5: A shift of bit 8 without next_rd_i also ends the word, and the next cycle presents bit 0 of the following word.
- R6: A shift while empty_o is 1 has no effect: ser_o stays 0, and a word written afterwards appears starting at its bit 0.
- R7: With N words held (written and not yet finished) and DEPTH the capacity, full_o = (N == DEPTH), empty_o = (N == 0), half_o = (N >= DEPTH/2), edge_o = (N <= DEPTH/8 or N >= DEPTH - DEPTH/8).
- R8: A write while full_o is 1 is dropped; the stored words and their order are unchanged.
- R9: A write and a word end in the same cycle both take effect and leave N unchanged.
- R10: A retransmit pulse, when at most DEPTH words have been written since reset, sets N to the number of words written since reset and presents bit 0 of the first of them; writes and shifts in a retransmit cycle are dropped.
- R11: A retransmit pulse after more than DEPTH words have been written since reset has no effect on N, the flags or ser_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write the parallel word this cycle |
| wr_data_i | input | 9 | Parallel write word |
| sh_en_i | input | 1 | Advance the serial output by one bit |
| next_rd_i | input | 1 | With sh_en_i: current bit ends the word |
| rexmit_i | input | 1 | Rewind to the first word written since reset |
| ser_o | output | 1 | Serial data, low while empty |
| full_o | output | 1 | Buffer holds DEPTH words |
| empty_o | output | 1 | Buffer holds no word |
| half_o | output | 1 | At least half of DEPTH held |
| edge_o | output | 1 | Within DEPTH/8 of empty or of full |

## Verification
The assertions take for granted that DEPTH is a power of two of at least 8 and that rexmit_i is a single-cycle pulse kept apart from write and shift activity, since the bench never tests how a retransmit and a write overlap. They also assume the shift position is meaningful only while the buffer is not empty. The stimulus drives each of the three controls from tasks that raise one enable at a time, except in the one deliberate cycle where a write and a word end coincide, and it issues retransmit only when both enables are low.

// File: rtl/piso_fifo_pkg.sv
package piso_fifo_pkg;
  localparam int unsigned WORD_W = 9;

  typedef struct packed {
    logic full;
    logic empty;
    logic half;
    logic edge_near;
  } occ_flags_t;
endpackage

// File: rtl/piso_fifo_mem.sv
module piso_fifo_mem #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // head word read combinationally: zero fall-through
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/piso_fifo_ctrl.sv
module piso_fifo_ctrl
  import piso_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          word_end_i,
  input  logic          rexmit_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          rexmit_ok_o,
  output occ_flags_t    flags_o
);
  localparam logic [CW-1:0] CAP     = CW'(DEPTH);
  localparam logic [CW-1:0] LO_TH   = CW'(DEPTH / 8);
  localparam logic [CW-1:0] HI_TH   = CW'(DEPTH - DEPTH / 8);
  localparam logic [CW-1:0] HALF_TH = CW'(DEPTH / 2);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, wr_tot_q;
  logic          wr_acc, rd_acc;

  assign wr_acc      = wr_en_i && (cnt_q != CAP) && !rexmit_i;
  assign rd_acc      = word_end_i;
  assign rexmit_ok_o = rexmit_i && (wr_tot_q <= CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      wr_tot_q <= '0;
    end else if (rexmit_ok_o) begin
      rd_ptr_q <= '0;
      cnt_q    <= wr_tot_q;
    end else begin
      if (wr_acc) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_acc) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (wr_acc && !rd_acc)      cnt_q <= cnt_q + 1'b1;
      else if (rd_acc && !wr_acc) cnt_q <= cnt_q - 1'b1;
      // saturate one past capacity: beyond that retransmit is refused
      if (wr_acc && wr_tot_q <= CAP) wr_tot_q <= wr_tot_q + 1'b1;
    end
  end

  assign we_o    = wr_acc;
  assign waddr_o = wr_ptr_q;
  assign raddr_o = rd_ptr_q;

  always_comb begin
    flags_o.full      = (cnt_q == CAP);
    flags_o.empty     = (cnt_q == '0);
    flags_o.half      = (cnt_q >= HALF_TH);
    flags_o.edge_near = (cnt_q <= LO_TH) || (cnt_q >= HI_TH);
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CAP) && !word_end_i |=> $stable(wr_ptr_q) && (cnt_q == CAP));

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && !wr_en_i && !rexmit_i |=> $stable(rd_ptr_q) && (cnt_q == '0));

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CAP);

  p_simul_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && rd_acc |=> $stable(cnt_q));

  p_rexmit_rewind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rexmit_ok_o |=> (rd_ptr_q == '0) && (cnt_q == $past(wr_tot_q)));

  p_rexmit_refused_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rexmit_i && (wr_tot_q > CAP) |=> $stable(rd_ptr_q) && $stable(cnt_q));
endmodule

// File: rtl/piso_fifo_shifter.sv
module piso_fifo_shifter #(
  parameter int unsigned W = 9,
  localparam int unsigned BW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sh_en_i,
  input  logic         next_rd_i,
  input  logic         empty_i,
  input  logic         rexmit_i,
  input  logic         rexmit_ok_i,
  input  logic [W-1:0] word_i,
  output logic         ser_o,
  output logic         word_end_o
);
  localparam logic [BW-1:0] LAST = BW'(W - 1);

  logic [BW-1:0] bit_q;
  logic          step;

  assign step       = sh_en_i && !empty_i && !rexmit_i;
  assign word_end_o = step && (next_rd_i || bit_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  bit_q <= '0;
    else if (rexmit_ok_i)         bit_q <= '0;
    else if (word_end_o)          bit_q <= '0;
    else if (step)                bit_q <= bit_q + 1'b1;
  end

  assign ser_o = !empty_i && word_i[bit_q];

  p_bit_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= LAST);

  p_auto_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && (bit_q == LAST) |=> bit_q == '0);

  p_next_rd_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && next_rd_i |=> bit_q == '0);

  p_idle_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i && !rexmit_i |=> $stable(bit_q));
endmodule

// File: rtl/piso_fifo.sv
module piso_fifo
  import piso_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              sh_en_i,
  input  logic              next_rd_i,
  input  logic              rexmit_i,
  output logic              ser_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              half_o,
  output logic              edge_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic              we, word_end, rexmit_ok;
  logic [AW-1:0]     waddr, raddr;
  logic [WORD_W-1:0] head;
  occ_flags_t        flags;

  piso_fifo_mem #(.W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (head)
  );

  piso_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .word_end_i  (word_end),
    .rexmit_i    (rexmit_i),
    .we_o        (we),
    .waddr_o     (waddr),
    .raddr_o     (raddr),
    .rexmit_ok_o (rexmit_ok),
    .flags_o     (flags)
  );

  piso_fifo_shifter #(.W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sh_en_i     (sh_en_i),
    .next_rd_i   (next_rd_i),
    .empty_i     (flags.empty),
    .rexmit_i    (rexmit_i),
    .rexmit_ok_i (rexmit_ok),
    .word_i      (head),
    .ser_o       (ser_o),
    .word_end_o  (word_end)
  );

  assign full_o  = flags.full;
  assign empty_o = flags.empty;
  assign half_o  = flags.half;
  assign edge_o  = flags.edge_near;

  initial begin
    p_depth_pow2_r7: assert ((DEPTH >= 8) && ((DEPTH & (DEPTH - 1)) == 0));
  end

  p_flag_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_fallthrough_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && wr_en_i && !rexmit_i |=> !empty_o && (ser_o == $past(wr_data_i[0])));
endmodule

// File: tb/sim_piso_fifo.sv
module sim_piso_fifo;
  localparam int unsigned DEPTH = 16;
  localparam int NV = 5;
  // [12:4] word, [3:0] serial length
  localparam logic [12:0] VEC [NV] = '{
    {9'h1A5, 4'd9}, {9'h0F3, 4'd7}, {9'h155, 4'd8},
    {9'h18C, 4'd1}, {9'h063, 4'd9}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, sh_en_i = 1'b0, next_rd_i = 1'b0, rexmit_i = 1'b0;
  logic [8:0] wr_data_i = '0;
  logic       ser_o, full_o, empty_o, half_o, edge_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] hist [64];
  int wr_cnt = 0, rd_abs = 0;

  always #5 clk_i = ~clk_i;

  piso_fifo #(.DEPTH(DEPTH)) u0 (.*);

  function automatic int occ();
    return wr_cnt - rd_abs;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic check_flags(string tag);
    int n = occ();
    check({tag, " full"},  full_o,  n == DEPTH);
    check({tag, " empty"}, empty_o, n == 0);
    check({tag, " half"},  half_o,  n >= DEPTH / 2);
    check({tag, " edge"},  edge_o,  (n <= DEPTH / 8) || (n >= DEPTH - DEPTH / 8));
  endtask

  task automatic do_write(logic [8:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
    if (occ() < DEPTH) begin hist[wr_cnt] = d; wr_cnt++; end
  endtask

  task automatic shift_word(int len, string tag);
    for (int b = 0; b < len; b++) begin
      sh_en_i = 1'b1;
      next_rd_i = (b == len - 1) && (len < 9);
      check(tag, ser_o, hist[rd_abs][b]);
      tick();
    end
    sh_en_i = 1'b0; next_rd_i = 1'b0;
    rd_abs++;
  endtask

  task automatic do_rexmit();
    rexmit_i = 1'b1;
    tick();
    rexmit_i = 1'b0;
    if (wr_cnt <= DEPTH) rd_abs = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check_flags("R1 in reset");
    check("R1 ser in reset", ser_o, 0);
    rst_ni = 1'b1;
    tick();
    check_flags("R1 after reset");
    check("R1 ser", ser_o, 0);

    // R6: shifting while empty is ignored
    sh_en_i = 1'b1;
    repeat (3) tick();
    sh_en_i = 1'b0;
    check("R6 ser empty", ser_o, 0);
    check("R6 still empty", empty_o, 1);

    // R2: zero fall-through, bit 0 of first word visible after write
    do_write(9'h0B6);
    check("R2 not empty", empty_o, 0);
    check("R2 first bit", ser_o, 0);
    do_write(9'h049);

    // table: load all, then shift each with its length
    for (int i = 0; i < NV; i++) do_write(VEC[i][12:4]);
    check_flags("R7 loaded 7");
    shift_word(9, "R6 R3 word after idle shifts");
    shift_word(9, "R3 R5 auto end");
    for (int i = 0; i < NV; i++) begin
      shift_word(int'(VEC[i][3:0]), VEC[i][3:0] == 4'd9 ? "R5 R3 auto len" : "R4 R3 next-read len");
      check_flags("R7 draining");
    end

    // R9: write and word end in one cycle
    do_write(9'h12D);
    wr_en_i = 1'b1; wr_data_i = 9'h0D2;
    sh_en_i = 1'b1; next_rd_i = 1'b1;
    check("R9 head bit", ser_o, hist[rd_abs][0]);
    tick();
    wr_en_i = 1'b0; sh_en_i = 1'b0; next_rd_i = 1'b0;
    hist[wr_cnt] = 9'h0D2; wr_cnt++; rd_abs++;
    check_flags("R9 count held");
    check("R9 next word bit", ser_o, 0);
    shift_word(9, "R9 word");

    // R10: retransmit with 9 words written
    do_rexmit();
    check_flags("R10 restored");
    check("R10 first bit", ser_o, hist[0][0]);
    shift_word(9, "R10 replay 0");
    shift_word(9, "R10 replay 1");

    // R7: fill to full, flags per step
    for (int i = 0; i < 9; i++) begin
      do_write(9'(9'h101 + i * 37));
      check_flags("R7 filling");
    end
    check("R7 full", full_o, 1);

    // R8: write while full dropped
    do_write(9'h1FF);
    check_flags("R8 still full");
    for (int i = 0; i < DEPTH; i++) shift_word(9, "R8 order kept");
    check_flags("R8 drained");

    // R11: retransmit refused after more than DEPTH writes
    do_rexmit();
    check_flags("R11 flags unchanged");
    check("R11 ser", ser_o, 0);
    do_write(9'h0C3);
    check("R11 new head", ser_o, 1);
    check_flags("R11 one word");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule